// File: doc/BRIEF.md
# Lane-Partitioned Packed Adder

This block is a single 64-bit two-operand adder whose internal carry chain can be cut at fixed lane boundaries. With the chain whole it performs one wide addition; with the chain cut it performs two, four or eight narrow additions side by side in the same cycle. Each lane applies the same operation to its own slice of the operands, which suits packed media data held in one wide word.

A 2-bit mode input chooses the lane width. A subtract control turns every active lane into a subtractor: the B operand is inverted and each lane's carry-in is forced to 1. Each lane reports its own carry-out in a flag vector. The adder is built from byte-wide segments joined by gated carry links. A parameter places an optional register, with asynchronous active-low reset, on the result and the flags.

Top module: `simd_partitioned_adder`

## Requirements
- R1: With mode 2'b00 the result is (opa + opb) mod 2^64 and lane_cout[0] is the carry out of bit 63.
- R2: With mode 2'b01 there are two 32-bit lanes: lane k occupies bits 32k+31..32k and its sum is the lane slice of opa plus the lane slice of opb, mod 2^32.
- R3: With mode 2'b10 there are four 16-bit lanes: lane k occupies bits 16k+15..16k and its sum is taken mod 2^16.
- R4: With mode 2'b11 there are eight 8-bit lanes: lane k occupies bits 8k+7..8k and its sum is taken mod 2^8.
- R5: No carry crosses a lane boundary. An overflowing lane wraps to its own width and leaves its neighbour unchanged, and adding zero gives opa with all flags clear.
- R6: With sub = 1 each active lane yields (a_lane - b_lane) mod 2^w. Its flag is 1 exactly when a_lane >= b_lane as unsigned values (no borrow).
- R7: lane_cout bit k holds the carry-out of lane k, with lane 0 the least significant. Bits at or above the number of active lanes read 0.
- R8: With REG_OUT = 1, sum and lane_cout show the result for the inputs present at the previous rising clk edge. rst_n low clears both to zero at once, with no clock edge needed.
- R9: With REG_OUT = 0, sum and lane_cout follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode | input | 2 | Lane width select: 00 one 64-bit, 01 two 32-bit, 10 four 16-bit, 11 eight 8-bit |
| sub | input | 1 | 1 selects subtraction in every active lane |
| opa | input | DATA_W (64) | Packed operand A |
| opb | input | DATA_W (64) | Packed operand B |
| sum | output | DATA_W (64) | Packed result |
| lane_cout | output | DATA_W/SEG_W (8) | Carry-out per lane, lane 0 in bit 0 |

## Verification
The bench builds two copies with DATA_W = 64 and SEG_W = 8. One has REG_OUT = 1, which brings the one-cycle latency and the asynchronous clear into reach. The other has REG_OUT = 0, so the same stimulus can be checked in the cycle it is applied. Because both share the byte segmentation, every mode is exercised. This includes all-ones patterns that would carry through every boundary if any gated link leaked, and equal-operand subtractions that set every active flag.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  // Lane arrangement; the value is log2 of the lane count.
  typedef enum logic [1:0] {
    LANES_1 = 2'b00,
    LANES_2 = 2'b01,
    LANES_4 = 2'b10,
    LANES_8 = 2'b11
  } lane_mode_e;

  function automatic int unsigned lane_count(lane_mode_e m);
    return 32'd1 << m;
  endfunction

  function automatic int unsigned segs_per_lane(lane_mode_e m, int unsigned nseg);
    return nseg >> m;
  endfunction

  // A link into segment seg carries only when seg is not the first of a lane.
  function automatic logic link_passes(lane_mode_e m, int unsigned seg, int unsigned nseg);
    return (seg % segs_per_lane(m, nseg)) != 0;
  endfunction

  // Index of the segment whose carry-out is the carry-out of lane k.
  function automatic int unsigned lane_top_seg(lane_mode_e m, int unsigned k, int unsigned nseg);
    return (k + 1) * segs_per_lane(m, nseg) - 1;
  endfunction

endpackage

// File: rtl/simd_carry_gate.sv
module simd_carry_gate
  import simd_add_pkg::*;
#(
  parameter int unsigned NSEG = 8
) (
  input  lane_mode_e       mode,
  output logic [NSEG-1:0]  link_open
);

  for (genvar i = 0; i < NSEG; i++) begin : g_link
    if (i == 0) begin : g_first
      assign link_open[i] = 1'b0;
    end else begin : g_rest
      assign link_open[i] = link_passes(mode, i, NSEG);
    end
  end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);

  logic [W-1:0] b_eff;
  logic [W:0]   total;

  assign b_eff = inv_b ? ~b : b;
  assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign s     = total[W-1:0];
  assign cout  = total[W];

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned NSEG    = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d_sum,
  input  logic [NSEG-1:0]   d_flags,
  output logic [DATA_W-1:0] q_sum,
  output logic [NSEG-1:0]   q_flags
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_sum   <= '0;
        q_flags <= '0;
      end else begin
        q_sum   <= d_sum;
        q_flags <= d_flags;
      end
    end
  end else begin : g_wire
    assign q_sum   = d_sum;
    assign q_flags = d_flags;
  end

endmodule

// File: rtl/simd_partitioned_adder.sv
module simd_partitioned_adder
  import simd_add_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SEG_W   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode,
  input  logic                      sub,
  input  logic [DATA_W-1:0]         opa,
  input  logic [DATA_W-1:0]         opb,
  output logic [DATA_W-1:0]         sum,
  output logic [DATA_W/SEG_W-1:0]   lane_cout
);

  localparam int unsigned NSEG = DATA_W / SEG_W;

  lane_mode_e         mode_e;
  logic [NSEG-1:0]    link_open;
  logic [NSEG-1:0]    seg_cin;
  logic [NSEG-1:0]    seg_cout;
  logic [DATA_W-1:0]  comb_sum;
  logic [NSEG-1:0]    comb_flags;

  assign mode_e = lane_mode_e'(mode);

  simd_carry_gate #(.NSEG(NSEG)) u_gate (
    .mode      (mode_e),
    .link_open (link_open)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_base
      assign seg_cin[g] = sub;
    end else begin : g_linked
      assign seg_cin[g] = link_open[g] ? seg_cout[g-1] : sub;
    end

    simd_seg_adder #(.W(SEG_W)) u_add (
      .a     (opa[g*SEG_W +: SEG_W]),
      .b     (opb[g*SEG_W +: SEG_W]),
      .inv_b (sub),
      .cin   (seg_cin[g]),
      .s     (comb_sum[g*SEG_W +: SEG_W]),
      .cout  (seg_cout[g])
    );
  end

  always_comb begin
    comb_flags = '0;
    for (int unsigned k = 0; k < NSEG; k++) begin
      if (k < lane_count(mode_e)) begin
        comb_flags[k] = seg_cout[lane_top_seg(mode_e, k, NSEG)];
      end
    end
  end

  simd_out_stage #(.DATA_W(DATA_W), .NSEG(NSEG), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_sum   (comb_sum),
    .d_flags (comb_flags),
    .q_sum   (sum),
    .q_flags (lane_cout)
  );

endmodule

// File: rtl/simd_partitioned_adder_chk.sv
module simd_partitioned_adder_chk
  import simd_add_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SEG_W   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode,
  input logic                     sub,
  input logic [DATA_W-1:0]        opa,
  input logic [DATA_W-1:0]        opb,
  input logic [DATA_W-1:0]        sum,
  input logic [DATA_W/SEG_W-1:0]  lane_cout,
  input logic [DATA_W-1:0]        comb_sum,
  input logic [DATA_W/SEG_W-1:0]  comb_flags,
  input logic [DATA_W/SEG_W-1:0]  link_open,
  input logic [DATA_W/SEG_W-1:0]  seg_cin
);

  localparam int unsigned NSEG = DATA_W / SEG_W;

  logic [NSEG-1:0] active_mask;
  always_comb begin
    for (int unsigned k = 0; k < NSEG; k++) begin
      active_mask[k] = (k < lane_count(lane_mode_e'(mode)));
    end
  end

  // R5: a segment whose link is closed starts from the fresh lane carry-in.
  p_closed_link_fresh_cin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_cin ^ {NSEG{sub}}) & ~link_open) == '0);

  // R5: adding zero never produces a carry in any lane.
  p_add_zero_identity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && opb == '0) |-> (comb_sum == opa && comb_flags == '0));

  // R6: equal operands subtract to zero with every active lane free of borrow.
  p_self_sub_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && opa == opb) |-> (comb_sum == '0 && comb_flags == active_mask));

  // R7: flags above the active lane count stay clear.
  p_unused_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_flags & ~active_mask) == '0);

  if (REG_OUT) begin : g_reg_chk
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
    end
    // R8: registered outputs repeat the previous cycle's combinational result.
    p_reg_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (sum == $past(comb_sum) && lane_cout == $past(comb_flags)));
  end else begin : g_comb_chk
    // R9: outputs equal the combinational result.
    p_comb_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sum == comb_sum && lane_cout == comb_flags));
  end

endmodule

bind simd_partitioned_adder simd_partitioned_adder_chk #(
  .DATA_W(DATA_W), .SEG_W(SEG_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .sub        (sub),
  .opa        (opa),
  .opb        (opb),
  .sum        (sum),
  .lane_cout  (lane_cout),
  .comb_sum   (comb_sum),
  .comb_flags (comb_flags),
  .link_open  (link_open),
  .seg_cin    (seg_cin)
);

// File: tb/simd_partitioned_adder_test.sv
`timescale 1ns/1ps
module simd_partitioned_adder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [63:0] sum_r, sum_c;
  logic [7:0]  fl_r, fl_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] s;
    logic [7:0]  f;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  simd_partitioned_adder #(.DATA_W(64), .SEG_W(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sub(sub),
    .opa(opa), .opb(opb), .sum(sum_r), .lane_cout(fl_r)
  );

  simd_partitioned_adder #(.DATA_W(64), .SEG_W(8), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sub(sub),
    .opa(opa), .opb(opb), .sum(sum_c), .lane_cout(fl_c)
  );

  // Behavioural model: lanes of width 64 >> m, built bit by bit.
  function automatic void ref_add(input int m, input bit s, input logic [63:0] a,
                                  input logic [63:0] b, output logic [63:0] r,
                                  output logic [7:0] f);
    int lanes = 1 << m;
    int w = 64 / lanes;
    r = '0;
    f = '0;
    for (int k = 0; k < lanes; k++) begin
      logic [64:0] al, bl, t;
      al = '0;
      bl = '0;
      for (int j = 0; j < w; j++) begin
        al[j] = a[k*w + j];
        bl[j] = s ? ~b[k*w + j] : b[k*w + j];
      end
      t = al + bl + {64'd0, s};
      for (int j = 0; j < w; j++) r[k*w + j] = t[j];
      f[k] = t[w];
    end
  endfunction

  task automatic check(string tag, logic [63:0] as, logic [7:0] af,
                       logic [63:0] es, logic [7:0] ef);
    checks++;
    if (as !== es || af !== ef) begin
      fails++;
      $display("FAIL %s: actual sum %h flags %b, expected sum %h flags %b",
               tag, as, af, es, ef);
    end
  endtask

  task automatic step(string tag, int m, bit s, logic [63:0] a, logic [63:0] b);
    logic [63:0] er;
    logic [7:0]  ef;
    exp_t e;
    @(negedge clk);
    mode = m[1:0];
    sub  = s;
    opa  = a;
    opb  = b;
    ref_add(m, s, a, b, er, ef);
    #1;
    check({tag, " R9 same-cycle"}, sum_c, fl_c, er, ef);
    e.s = er; e.f = ef; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    e = exp_q.pop_front();
    check({e.tag, " R8 registered"}, sum_r, fl_r, e.s, e.f);
  endtask

  function automatic string mode_tag(int m, bit s);
    if (s) return "R6";
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: actual still running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    opa = 64'h0123_4567_89ab_cdef;
    opb = 64'hffff_0000_ffff_0000;
    repeat (2) @(posedge clk);
    #1;
    check("R8 reset clear", sum_r, fl_r, 64'd0, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: full-width wrap
    step("R1", 0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd1);
    step("R1", 0, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001);
    // R5: carries stop at every lane boundary
    step("R5", 3, 1'b0, 64'hffff_ffff_ffff_ffff, 64'h0101_0101_0101_0101);
    step("R5", 2, 1'b0, 64'h00ff_ffff_00ff_ffff, 64'h0001_0001_0001_0001);
    step("R5", 1, 1'b0, 64'h7fff_ffff_ffff_ffff, 64'd1);
    step("R5", 3, 1'b0, 64'hdead_beef_1234_5678, 64'd0);
    // R6: borrow and no-borrow lanes
    step("R6", 3, 1'b1, 64'd0, 64'h0101_0101_0101_0101);
    step("R6", 2, 1'b1, 64'h1234_0000_ffff_8000, 64'h1234_0001_0000_7fff);
    step("R6", 1, 1'b1, 64'h5555_aaaa_0000_0000, 64'h5555_aaaa_0000_0000);
    step("R6", 0, 1'b1, 64'd5, 64'd7);
    // R7: carries in every lane, upper flags must stay clear
    for (int m = 0; m < 4; m++)
      step("R7", m, 1'b0, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);

    // R2, R3, R4 and mixed: random operands in every mode
    for (int i = 0; i < 256; i++) begin
      int m = i % 4;
      bit s = (i / 4) % 2;
      step(mode_tag(m, s), m, s, {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R8: asynchronous clear without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", sum_r, fl_r, 64'd0, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R4", 3, 1'b0, 64'h8080_8080_8080_8080, 64'h8081_7f80_0180_ff80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule